// File: doc/BRIEF.md
# Request Legality Front-End

This block sits at the device side of a simple request/response bus with a request channel (host to device) and a response channel (device to host). It accepts one request per handshake and checks the request's fields. A request that passes is handed to a memory-like backend in the same cycle. The block then returns that backend's answer on the response channel in the next cycle. A request that breaks any rule never reaches the backend. The block answers it itself, with the error flag raised.

Responses are held in a single-entry buffer. Every response echoes the size and source of the request it answers, and its opcode follows from the kind of request. The request channel stalls only while the buffer is full and the host is not taking the response. When the host keeps its response ready high, the block sustains one transfer per cycle. The backend is assumed to answer reads combinationally in the cycle it is addressed.

Top module: `req_guard`

## Requirements
- R1: During and right after a synchronous active-high reset, `d_valid` and `be_req` are low and `a_ready` is high.
- R2: Only the request opcodes 0 (full write), 1 (partial write) and 4 (read) are legal. Any other opcode value produces a response with `d_error` high and is not forwarded.
- R3: A request whose `a_param` field is non-zero is answered with `d_error` high and is not forwarded.
- R4: A request is an error when 2^`a_size` exceeds the number of byte lanes, or when 2^`a_size` is smaller than the number of set `a_mask` bits.
- R5: For a full write (opcode 0), 2^`a_size` must equal the number of set `a_mask` bits, otherwise the request is an error.
- R6: A request whose low `a_size` address bits are not all zero is an error.
- R7: For reads and full writes, the set bits of `a_mask` must form one contiguous run, which may start at any lane. An empty mask counts as contiguous. Partial writes may use any mask pattern.
- R8: A legal request raises `be_req` in the cycle it is accepted. In that cycle `be_write` is high for opcodes 0 and 1, and `be_addr`, `be_mask` and `be_wdata` carry the request's fields. An illegal request never raises `be_req`.
- R9: The response appears on the cycle after acceptance. `d_opcode` is 1 (data acknowledge) for opcode 4 and 0 (plain acknowledge) for every other opcode. `d_size` and `d_source` equal the request's `a_size` and `a_source`. A response is only issued for a source that has a request pending.
- R10: On a legal read, each byte lane of `d_data` carries the backend data where the request's mask bit is set and zero where it is clear. Write acknowledges and all error responses carry zero data.
- R11: While `d_valid` is high and `d_ready` is low, `a_ready` is low and every response field holds its value until the response is taken.
- R12: With `d_ready` held high, a new request is accepted on every cycle, and each response follows its request by exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_valid | input | 1 | Request valid |
| a_ready | output | 1 | Request accepted when high together with a_valid |
| a_opcode | input | 3 | Request opcode (0 full write, 1 partial write, 4 read) |
| a_param | input | 3 | Reserved request field, must be zero |
| a_size | input | SIZE_W | Log2 of the transfer size in bytes |
| a_source | input | SRC_W | Requester identifier |
| a_address | input | ADDR_W | Byte address |
| a_mask | input | DATA_W/8 | Byte-lane enables |
| a_data | input | DATA_W | Write data |
| d_valid | output | 1 | Response valid |
| d_ready | input | 1 | Host can take the response |
| d_opcode | output | 3 | Response opcode (0 plain acknowledge, 1 data acknowledge) |
| d_size | output | SIZE_W | Echo of the request size |
| d_source | output | SRC_W | Echo of the request source |
| d_error | output | 1 | Request was rejected |
| d_data | output | DATA_W | Read data, zero in lanes not enabled |
| be_req | output | 1 | Backend access strobe |
| be_write | output | 1 | Backend access is a write |
| be_addr | output | ADDR_W | Backend byte address |
| be_mask | output | DATA_W/8 | Backend byte enables |
| be_wdata | output | DATA_W | Backend write data |
| be_rdata | input | DATA_W | Backend read data, valid in the cycle of be_req |

## Verification
The hardest situation to reach is a request that arrives while an older response is still stalled. In that case the buffer must refuse the newcomer and keep every field of the old response frozen. When the host finally takes the old response, the waiting request must be accepted in that same cycle. The bench gets there by holding `d_ready` low for several cycles with a second request already driven. It then raises `d_ready` and checks the handover cycle. Around that, an exhaustive sweep covers every opcode value, size, 4-bit mask and low address offset. Each sweep entry's error verdict, forwarding and data lanes are checked against values worked out arithmetically.

// File: rtl/req_guard_pkg.sv
package req_guard_pkg;

    // Request kinds; the encodings are fixed by the bus.
    typedef enum logic [2:0] {
        REQ_WR_FULL = 3'd0,
        REQ_WR_PART = 3'd1,
        REQ_RD      = 3'd4
    } req_kind_e;

    // Response kinds.
    typedef enum logic [2:0] {
        RSP_ACK      = 3'd0,
        RSP_ACK_DATA = 3'd1
    } rsp_kind_e;

    // One flag per rule that a request can break.
    typedef struct packed {
        logic bad_op;
        logic bad_param;
        logic too_wide;
        logic mask_over;
        logic full_mismatch;
        logic misaligned;
        logic gappy;
    } rule_flags_t;

    // Population count of up to eight lane enables.
    function automatic logic [3:0] ones8(input logic [7:0] v);
        logic [3:0] n;
        n = '0;
        for (int i = 0; i < 8; i++) begin
            n = n + {3'b000, v[i]};
        end
        return n;
    endfunction

    // True when the set bits form a single unbroken run (or none).
    // Adding the lowest set bit carries through the run; any bit left
    // overlapping the original pattern means a second run exists.
    function automatic logic run8(input logic [7:0] v);
        logic [8:0] wide, lowest, carried;
        wide    = {1'b0, v};
        lowest  = wide & (~wide + 9'd1);
        carried = wide + lowest;
        return (carried[7:0] & v) == 8'h00;
    endfunction

    function automatic logic op_known(input logic [2:0] op);
        return (op == REQ_WR_FULL) || (op == REQ_WR_PART) || (op == REQ_RD);
    endfunction

endpackage

// File: rtl/req_guard_rules.sv
module req_guard_rules
    import req_guard_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ADDR_W = 12,
    parameter int SIZE_W = 2
) (
    input  logic [2:0]        op,
    input  logic [2:0]        param,
    input  logic [SIZE_W-1:0] size,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  mask,
    output rule_flags_t       flags,
    output logic              legal
);
    localparam int LANE_LOG = $clog2(LANES);

    logic [31:0]       nbytes;
    logic [31:0]       set_cnt;
    logic [ADDR_W-1:0] low_bits;
    logic              needs_run;

    always_comb begin
        nbytes    = 32'd1 << size;
        set_cnt   = 32'(ones8(8'(mask)));
        low_bits  = ADDR_W'(nbytes - 32'd1);
        needs_run = (op == REQ_RD) || (op == REQ_WR_FULL);

        flags.bad_op        = !op_known(op);
        flags.bad_param     = (param != 3'd0);
        flags.too_wide      = (int'(size) > LANE_LOG);
        flags.mask_over     = (nbytes < set_cnt);
        flags.full_mismatch = (op == REQ_WR_FULL) && (nbytes != set_cnt);
        flags.misaligned    = ((addr & low_bits) != '0);
        flags.gappy         = needs_run && !run8(8'(mask));

        legal = (flags == '0);
    end

endmodule

// File: rtl/req_guard_rsp_buf.sv
module req_guard_rsp_buf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    logic         full;
    logic [W-1:0] held;

    // Room exists when empty, or when the held entry leaves this cycle.
    assign in_ready  = !full || out_ready;
    assign out_valid = full;
    assign out_data  = held;

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            held <= '0;
        end else if (in_valid && in_ready) begin
            full <= 1'b1;
            held <= in_data;
        end else if (out_ready) begin
            full <= 1'b0;
        end
    end

endmodule

// File: rtl/req_guard.sv
module req_guard
    import req_guard_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12,
    parameter int SRC_W  = 4,
    parameter int SIZE_W = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                a_valid,
    output logic                a_ready,
    input  logic [2:0]          a_opcode,
    input  logic [2:0]          a_param,
    input  logic [SIZE_W-1:0]   a_size,
    input  logic [SRC_W-1:0]    a_source,
    input  logic [ADDR_W-1:0]   a_address,
    input  logic [DATA_W/8-1:0] a_mask,
    input  logic [DATA_W-1:0]   a_data,
    output logic                d_valid,
    input  logic                d_ready,
    output logic [2:0]          d_opcode,
    output logic [SIZE_W-1:0]   d_size,
    output logic [SRC_W-1:0]    d_source,
    output logic                d_error,
    output logic [DATA_W-1:0]   d_data,
    output logic                be_req,
    output logic                be_write,
    output logic [ADDR_W-1:0]   be_addr,
    output logic [DATA_W/8-1:0] be_mask,
    output logic [DATA_W-1:0]   be_wdata,
    input  logic [DATA_W-1:0]   be_rdata
);
    localparam int LANES  = DATA_W / 8;
    localparam int RSP_W  = 1 + 3 + SIZE_W + SRC_W + DATA_W;
    localparam int P_SRC  = DATA_W;
    localparam int P_SIZE = P_SRC + SRC_W;
    localparam int P_OP   = P_SIZE + SIZE_W;
    localparam int P_ERR  = P_OP + 3;

    rule_flags_t       flags;
    logic              legal;
    logic              take;
    logic              is_read;
    rsp_kind_e         rsp_kind;
    logic [DATA_W-1:0] rd_lanes;
    logic [DATA_W-1:0] rsp_data;
    logic [RSP_W-1:0]  rsp_in;
    logic [RSP_W-1:0]  rsp_out;

    req_guard_rules #(
        .LANES  (LANES),
        .ADDR_W (ADDR_W),
        .SIZE_W (SIZE_W)
    ) u_rules (
        .op    (a_opcode),
        .param (a_param),
        .size  (a_size),
        .addr  (a_address),
        .mask  (a_mask),
        .flags (flags),
        .legal (legal)
    );

    // Keep only the lanes the request enabled.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rd_lanes[8*g +: 8] = a_mask[g] ? be_rdata[8*g +: 8] : 8'h00;
    end

    assign take    = a_valid && a_ready;
    assign is_read = (a_opcode == REQ_RD);

    // Backend side: only legal requests pass.
    assign be_req   = take && legal;
    assign be_write = !is_read;
    assign be_addr  = a_address;
    assign be_mask  = a_mask;
    assign be_wdata = a_data;

    // Response formation.
    assign rsp_kind = is_read ? RSP_ACK_DATA : RSP_ACK;
    assign rsp_data = (legal && is_read) ? rd_lanes : '0;
    assign rsp_in   = {!legal, 3'(rsp_kind), a_size, a_source, rsp_data};

    req_guard_rsp_buf #(
        .W (RSP_W)
    ) u_buf (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (a_valid),
        .in_ready  (a_ready),
        .in_data   (rsp_in),
        .out_valid (d_valid),
        .out_ready (d_ready),
        .out_data  (rsp_out)
    );

    assign d_error  = rsp_out[P_ERR];
    assign d_opcode = rsp_out[P_OP +: 3];
    assign d_size   = rsp_out[P_SIZE +: SIZE_W];
    assign d_source = rsp_out[P_SRC +: SRC_W];
    assign d_data   = rsp_out[DATA_W-1:0];

endmodule

// File: rtl/req_guard_sva.sv
module req_guard_sva #(
    parameter int DATA_W = 32,
    parameter int SRC_W  = 4,
    parameter int SIZE_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              a_valid,
    input logic              a_ready,
    input logic [2:0]        a_opcode,
    input logic [2:0]        a_param,
    input logic [SIZE_W-1:0] a_size,
    input logic [SRC_W-1:0]  a_source,
    input logic              d_valid,
    input logic              d_ready,
    input logic [2:0]        d_opcode,
    input logic [SIZE_W-1:0] d_size,
    input logic [SRC_W-1:0]  d_source,
    input logic              d_error,
    input logic [DATA_W-1:0] d_data,
    input logic              be_req
);
    localparam int NSRC = 1 << SRC_W;

    logic            take;
    logic [NSRC-1:0] pend;

    assign take = a_valid && a_ready;

    // Outstanding-request table, one bit per source.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else begin
            if (d_valid && d_ready) pend[d_source] <= 1'b0;
            if (take)               pend[a_source] <= 1'b1;
        end
    end

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!d_valid && a_ready));

    a_r2_fwd_known_op: assert property (@(posedge clk) disable iff (rst)
        be_req |-> (a_opcode == 3'd0 || a_opcode == 3'd1 || a_opcode == 3'd4));

    a_r3_fwd_zero_param: assert property (@(posedge clk) disable iff (rst)
        be_req |-> (a_param == 3'd0));

    a_r9_resp_next_cycle: assert property (@(posedge clk) disable iff (rst)
        take |=> (d_valid && d_size == $past(a_size) && d_source == $past(a_source)));

    a_r9_source_pending: assert property (@(posedge clk) disable iff (rst)
        d_valid |-> pend[d_source]);

    a_r10_error_no_data: assert property (@(posedge clk) disable iff (rst)
        (d_valid && d_error) |-> (d_data == '0));

    a_r11_stall_blocks: assert property (@(posedge clk) disable iff (rst)
        (d_valid && !d_ready) |-> !a_ready);

    a_r11_fields_hold: assert property (@(posedge clk) disable iff (rst)
        (d_valid && !d_ready) |=> (d_valid && $stable(d_opcode) && $stable(d_size) &&
                                   $stable(d_source) && $stable(d_error) && $stable(d_data)));

endmodule

bind req_guard req_guard_sva #(
    .DATA_W (DATA_W),
    .SRC_W  (SRC_W),
    .SIZE_W (SIZE_W)
) u_sva (
    .clk      (clk),
    .rst      (rst),
    .a_valid  (a_valid),
    .a_ready  (a_ready),
    .a_opcode (a_opcode),
    .a_param  (a_param),
    .a_size   (a_size),
    .a_source (a_source),
    .d_valid  (d_valid),
    .d_ready  (d_ready),
    .d_opcode (d_opcode),
    .d_size   (d_size),
    .d_source (d_source),
    .d_error  (d_error),
    .d_data   (d_data),
    .be_req   (be_req)
);

// File: tb/tb_req_guard.sv
`timescale 1ns/1ps
module tb_req_guard;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;
    localparam int SRC_W  = 4;
    localparam int SIZE_W = 2;
    localparam int LANES  = DATA_W / 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              a_valid = 1'b0;
    logic              a_ready;
    logic [2:0]        a_opcode = '0;
    logic [2:0]        a_param = '0;
    logic [SIZE_W-1:0] a_size = '0;
    logic [SRC_W-1:0]  a_source = '0;
    logic [ADDR_W-1:0] a_address = '0;
    logic [LANES-1:0]  a_mask = '0;
    logic [DATA_W-1:0] a_data = '0;
    logic              d_valid;
    logic              d_ready = 1'b0;
    logic [2:0]        d_opcode;
    logic [SIZE_W-1:0] d_size;
    logic [SRC_W-1:0]  d_source;
    logic              d_error;
    logic [DATA_W-1:0] d_data;
    logic              be_req;
    logic              be_write;
    logic [ADDR_W-1:0] be_addr;
    logic [LANES-1:0]  be_mask;
    logic [DATA_W-1:0] be_wdata;
    logic [DATA_W-1:0] be_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    req_guard #(
        .DATA_W (DATA_W), .ADDR_W (ADDR_W), .SRC_W (SRC_W), .SIZE_W (SIZE_W)
    ) dut (
        .clk (clk), .rst (rst),
        .a_valid (a_valid), .a_ready (a_ready), .a_opcode (a_opcode),
        .a_param (a_param), .a_size (a_size), .a_source (a_source),
        .a_address (a_address), .a_mask (a_mask), .a_data (a_data),
        .d_valid (d_valid), .d_ready (d_ready), .d_opcode (d_opcode),
        .d_size (d_size), .d_source (d_source), .d_error (d_error),
        .d_data (d_data),
        .be_req (be_req), .be_write (be_write), .be_addr (be_addr),
        .be_mask (be_mask), .be_wdata (be_wdata), .be_rdata (be_rdata)
    );

    // Backend model: 16 words, combinational read, byte-masked write.
    logic [DATA_W-1:0] mem [0:15];
    assign be_rdata = mem[be_addr[5:2]];

    always @(posedge clk) begin
        if (be_req && be_write) begin
            for (int l = 0; l < LANES; l++) begin
                if (be_mask[l]) mem[be_addr[5:2]][8*l +: 8] <= be_wdata[8*l +: 8];
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int pop(input int m);
        int c = 0;
        for (int i = 0; i < LANES; i++) c += (m >> i) & 1;
        return c;
    endfunction

    // Contiguity by scanning: count transitions from clear to set.
    function automatic bit one_run(input int m);
        int starts = 0;
        int prev = 0;
        for (int i = 0; i < LANES; i++) begin
            int b = (m >> i) & 1;
            if (b == 1 && prev == 0) starts++;
            prev = b;
        end
        return starts <= 1;
    endfunction

    // Error verdict and the requirement naming the first broken rule.
    function automatic string verdict(input int op, input int prm, input int sz,
                                      input int addr, input int m);
        int nb = 1 << sz;
        if (!(op == 0 || op == 1 || op == 4)) return "R2";
        if (prm != 0)                         return "R3";
        if (nb > LANES || nb < pop(m))        return "R4";
        if (op == 0 && nb != pop(m))          return "R5";
        if ((addr & (nb - 1)) != 0)           return "R6";
        if ((op == 0 || op == 4) && !one_run(m)) return "R7";
        return "";
    endfunction

    function automatic logic [DATA_W-1:0] lane_fill(input int m);
        logic [DATA_W-1:0] r = '0;
        for (int i = 0; i < LANES; i++) if ((m >> i) & 1) r[8*i +: 8] = 8'hFF;
        return r;
    endfunction

    // One request with a one-cycle stall on the response side.
    task automatic do_req(input int op, input int prm, input int sz, input int addr,
                          input int m, input logic [DATA_W-1:0] wd, input int src);
        string why = verdict(op, prm, sz, addr, m);
        bit bad = (why != "");
        string tag = bad ? why : "R8";
        logic [DATA_W-1:0] exp_d;
        exp_d = (!bad && op == 4) ? (mem[addr[5:2]] & lane_fill(m)) : '0;

        @(negedge clk);
        a_valid = 1'b1; a_opcode = 3'(op); a_param = 3'(prm); a_size = SIZE_W'(sz);
        a_address = ADDR_W'(addr); a_mask = LANES'(m); a_data = wd; a_source = SRC_W'(src);
        d_ready = 1'b0;
        #1;
        chk({tag, " be_req"}, be_req, !bad);
        if (!bad) begin
            chk("R8 be_write", be_write, op != 4);
            chk("R8 be_addr", be_addr, addr);
            chk("R8 be_mask", be_mask, m);
            if (op != 4) chk("R8 be_wdata", be_wdata, wd);
        end
        @(negedge clk);
        a_valid = 1'b0;
        #1;
        chk("R9 d_valid", d_valid, 1);
        chk({tag, " d_error"}, d_error, bad);
        chk("R9 d_opcode", d_opcode, (op == 4) ? 1 : 0);
        chk("R9 d_size", d_size, sz);
        chk("R9 d_source", d_source, src);
        chk("R10 d_data", d_data, exp_d);
        chk("R11 a_ready stalled", a_ready, 0);
        d_ready = 1'b1;
        @(negedge clk);
        d_ready = 1'b0;
        #1;
        chk("R11 released", d_valid, 0);
    endtask

    initial begin
        #(10 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        int src = 0;
        for (int i = 0; i < 16; i++) mem[i] = 32'hC3A50000 ^ (32'(i) * 32'h01030507);

        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R1 d_valid", d_valid, 0);
        chk("R1 be_req", be_req, 0);
        chk("R1 a_ready", a_ready, 1);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk("R1 after release d_valid", d_valid, 0);
        chk("R1 after release a_ready", a_ready, 1);

        // Exhaustive sweep: opcode, size, mask, low address offset (R2..R10).
        for (int op = 0; op < 8; op++)
            for (int sz = 0; sz < 4; sz++)
                for (int m = 0; m < 16; m++)
                    for (int lo = 0; lo < 4; lo++) begin
                        int idx = (m + op + sz) % 16;
                        do_req(op, 0, sz, (idx << 2) | lo, m,
                               {8'(op), 8'(sz), 8'(m), 8'(lo) ^ 8'h5A}, src);
                        src = (src + 1) % 16;
                    end

        // Reserved field sweep on otherwise legal requests (R3).
        for (int p = 1; p < 8; p++) begin
            do_req(4, p, 2, 8, 15, '0, p);
            do_req(0, p, 1, 2, 12, 32'h11223344, p);
        end

        // Stall with a second request waiting (R11), then handover.
        @(negedge clk);
        a_valid = 1'b1; a_opcode = 3'd4; a_param = 0; a_size = 2; a_address = 12'h010;
        a_mask = 4'hF; a_source = 4'd3; d_ready = 1'b0;
        @(negedge clk);
        a_source = 4'd9; a_opcode = 3'd1; a_mask = 4'h5; a_size = 2; a_address = 12'h020;
        a_data = 32'hDEADBEEF;
        for (int k = 0; k < 5; k++) begin
            #1;
            chk("R11 held valid", d_valid, 1);
            chk("R11 held source", d_source, 3);
            chk("R11 held data", d_data, mem[4]);
            chk("R11 blocked a_ready", a_ready, 0);
            chk("R11 nothing forwarded", be_req, 0);
            @(negedge clk);
        end
        d_ready = 1'b1;
        #1;
        chk("R11 handover a_ready", a_ready, 1);
        chk("R11 handover forwarded", be_req, 1);
        @(negedge clk);
        a_valid = 1'b0;
        #1;
        chk("R11 new response", d_source, 9);
        chk("R11 new opcode", d_opcode, 0);
        @(negedge clk);
        #1;
        chk("R11 drained", d_valid, 0);

        // Back-to-back with d_ready held high (R12).
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            a_valid = 1'b1; a_opcode = 3'd4; a_param = 0; a_size = 0;
            a_address = ADDR_W'(k); a_mask = LANES'(1 << k % 4); a_source = SRC_W'(k + 4);
            #1;
            chk("R12 a_ready", a_ready, 1);
            if (k > 0) begin
                chk("R12 d_valid", d_valid, 1);
                chk("R12 d_source", d_source, k + 3);
            end
        end
        @(negedge clk);
        a_valid = 1'b0;
        #1;
        chk("R12 last d_source", d_source, 9);
        @(negedge clk);
        d_ready = 1'b0;
        #1;
        chk("R12 empty", d_valid, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule